// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the receive path, the transmit path, the link monitor, a timer and the system bus logic of a network controller. Each pulse sets a sticky bit in a 16-bit status register. A 16-bit enable register uses the same bit positions and selects which latched events may raise the single level-sensitive interrupt request.

Software reads both registers through a small word-wide register port. It clears handled events by writing ones to the status register, and it can force a software event through a separate command offset. Status bits latch whether or not they are enabled, so polling software can still see masked events. An event that arrives in the same cycle as a clear of its own bit is kept, so no event is lost during acknowledgement.

Top module: `irq_unit`

## Requirements
- R1: While the reset is asserted and after it is released, the status register reads 0x0000, the enable register reads 0x0000 and `irq_o` is low.
- R2: A one-cycle pulse on an event input sets its status bit on the next clock edge. The positions are: rx_done 0, rx_fault 1, tx_done 2, tx_fault 3, rx_ring_empty 4, link_event 5, rx_fifo_full 6, tx_ring_empty 7, software event 8, timer 14, bus_fault 15.
- R3: Status bits latch whether or not the enable register has them enabled, and they hold until software clears them.
- R4: A write to the status offset (address 1) clears every status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing 0xFFFF clears every bit.
- R5: When an event pulse and a write-one clear of the same bit happen in the same cycle, the bit is set after that edge.
- R6: A write to the command offset (address 2) with data bit 0 set sets status bit 8. The other data bits of that write have no effect, and bit 0 written as 0 has no effect.
- R7: A write to the enable offset (address 0) loads the enable register. A read returns its implemented bits at the same positions as the status bits.
- R8: `irq_o` is high exactly when some status bit and the same enable bit are both 1. An all-zero enable register holds `irq_o` low whatever the status.
- R9: Bits 9 to 13 of both registers read as 0, and writes to them are ignored.
- R10: Reads at the command offset (address 2) and at the unused offset (address 3) return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word offset: 0 enable, 1 status, 2 command, 3 unused |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| rx_done_i | input | 1 | Frame received without error |
| rx_fault_i | input | 1 | Frame received with error |
| tx_done_i | input | 1 | Frame sent |
| tx_fault_i | input | 1 | Transmit failed |
| rx_ring_empty_i | input | 1 | No receive descriptor available |
| link_event_i | input | 1 | Underrun or link state change |
| rx_fifo_full_i | input | 1 | Receive FIFO overflowed |
| tx_ring_empty_i | input | 1 | No transmit descriptor available |
| timer_i | input | 1 | Timer expired |
| bus_fault_i | input | 1 | System bus error |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is the race between software acknowledging a bit and the hardware raising the same bit again in that cycle. The stimulus forces it by driving an event pulse and an all-ones status write in one cycle, then reading the status back. It expects only the re-raised bit to remain. A second point needs care: a masked event must stay visible while `irq_o` stays low. The bench covers it by raising events with the enable register cleared, then enabling a bit only afterwards and watching the request rise.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;
    localparam int N_SRC  = 10;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_COMMAND = 2'd2,
        SEL_UNUSED  = 2'd3
    } reg_sel_e;

    localparam int POS_RX_DONE       = 0;
    localparam int POS_RX_FAULT      = 1;
    localparam int POS_TX_DONE       = 2;
    localparam int POS_TX_FAULT      = 3;
    localparam int POS_RX_RING_EMPTY = 4;
    localparam int POS_LINK_EVENT    = 5;
    localparam int POS_RX_FIFO_FULL  = 6;
    localparam int POS_TX_RING_EMPTY = 7;
    localparam int POS_SOFT          = 8;
    localparam int POS_TIMER         = 14;
    localparam int POS_BUS_FAULT     = 15;

    localparam int CMD_SOFT_BIT = 0;

    typedef struct packed {
        logic bus_fault;
        logic timer;
        logic tx_ring_empty;
        logic rx_fifo_full;
        logic link_event;
        logic rx_ring_empty;
        logic tx_fault;
        logic tx_done;
        logic rx_fault;
        logic rx_done;
    } evt_s;

    typedef struct packed {
        logic             ld_enable;
        logic             clr_status;
        logic             soft_raise;
        logic [REG_W-1:0] data;
    } reg_wr_s;

    function automatic logic [REG_W-1:0] bit_at(input int pos);
        logic [REG_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    localparam logic [REG_W-1:0] IMPL_BITS =
        bit_at(POS_RX_DONE) | bit_at(POS_RX_FAULT) | bit_at(POS_TX_DONE) |
        bit_at(POS_TX_FAULT) | bit_at(POS_RX_RING_EMPTY) | bit_at(POS_LINK_EVENT) |
        bit_at(POS_RX_FIFO_FULL) | bit_at(POS_TX_RING_EMPTY) | bit_at(POS_SOFT) |
        bit_at(POS_TIMER) | bit_at(POS_BUS_FAULT);

    function automatic logic [REG_W-1:0] evt_to_bits(input evt_s e);
        logic [REG_W-1:0] v;
        v = '0;
        v[POS_RX_DONE]       = e.rx_done;
        v[POS_RX_FAULT]      = e.rx_fault;
        v[POS_TX_DONE]       = e.tx_done;
        v[POS_TX_FAULT]      = e.tx_fault;
        v[POS_RX_RING_EMPTY] = e.rx_ring_empty;
        v[POS_LINK_EVENT]    = e.link_event;
        v[POS_RX_FIFO_FULL]  = e.rx_fifo_full;
        v[POS_TX_RING_EMPTY] = e.tx_ring_empty;
        v[POS_TIMER]         = e.timer;
        v[POS_BUS_FAULT]     = e.bus_fault;
        return v;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_unit_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output reg_wr_s       req_o
);
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(addr_i);
        req_o            = '0;
        req_o.data       = wdata_i;
        req_o.ld_enable  = wr_i && (sel == SEL_ENABLE);
        req_o.clr_status = wr_i && (sel == SEL_STATUS);
        req_o.soft_raise = wr_i && (sel == SEL_COMMAND) && wdata_i[CMD_SOFT_BIT];
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_unit_pkg::*;
#(
    parameter int DW = REG_W,
    parameter logic [DW-1:0] KEEP = IMPL_BITS
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    output logic [DW-1:0] sts_o
);
    logic [DW-1:0] sts_q;

    // new events win over a clear in the same cycle
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (KEEP[b]) begin : g_impl
            always_ff @(posedge clk_i) begin
                if (rst_i)          sts_q[b] <= 1'b0;
                else if (set_i[b])  sts_q[b] <= 1'b1;
                else if (clr_i[b])  sts_q[b] <= 1'b0;
            end
        end else begin : g_rsvd
            assign sts_q[b] = 1'b0;
        end
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_unit_pkg::*;
#(
    parameter int DW = REG_W,
    parameter logic [DW-1:0] KEEP = IMPL_BITS
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ld_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] en_o
);
    logic [DW-1:0] en_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)     en_q <= '0;
        else if (ld_i) en_q <= data_i & KEEP;
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_unit_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic [DW-1:0] sts_i,
    input  logic [DW-1:0] en_i,
    output logic          irq_o
);
    logic [DW-1:0] hit;

    for (genvar b = 0; b < DW; b++) begin : g_hit
        assign hit[b] = sts_i[b] & en_i[b];
    end

    assign irq_o = |hit;
endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_unit_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic              rx_done_i,
    input  logic              rx_fault_i,
    input  logic              tx_done_i,
    input  logic              tx_fault_i,
    input  logic              rx_ring_empty_i,
    input  logic              link_event_i,
    input  logic              rx_fifo_full_i,
    input  logic              tx_ring_empty_i,
    input  logic              timer_i,
    input  logic              bus_fault_i,
    output logic              irq_o
);
    reg_wr_s          req;
    evt_s             evt;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] msk_q;

    always_comb begin
        evt.rx_done       = rx_done_i;
        evt.rx_fault      = rx_fault_i;
        evt.tx_done       = tx_done_i;
        evt.tx_fault      = tx_fault_i;
        evt.rx_ring_empty = rx_ring_empty_i;
        evt.link_event    = link_event_i;
        evt.rx_fifo_full  = rx_fifo_full_i;
        evt.tx_ring_empty = tx_ring_empty_i;
        evt.timer         = timer_i;
        evt.bus_fault     = bus_fault_i;
    end

    irq_bus_decode #(.DW(REG_W), .AW(ADDR_W)) u_dec (
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .req_o   (req)
    );

    always_comb begin
        set_vec = evt_to_bits(evt);
        if (req.soft_raise) set_vec[POS_SOFT] = 1'b1;
        clr_vec = req.clr_status ? req.data : '0;
    end

    irq_status_reg #(.DW(REG_W), .KEEP(IMPL_BITS)) u_sts (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .sts_o (sts_q)
    );

    irq_enable_reg #(.DW(REG_W), .KEEP(IMPL_BITS)) u_en (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ld_i   (req.ld_enable),
        .data_i (req.data),
        .en_o   (msk_q)
    );

    irq_req_gen #(.DW(REG_W)) u_req (
        .sts_i (sts_q),
        .en_i  (msk_q),
        .irq_o (irq_o)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr_i))
            SEL_ENABLE: bus_rdata_o = msk_q;
            SEL_STATUS: bus_rdata_o = sts_q;
            default:    bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
    import irq_unit_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [REG_W-1:0]  bus_wdata_i,
    input logic              rx_done_i,
    input logic              bus_fault_i,
    input logic [REG_W-1:0]  sts_q,
    input logic [REG_W-1:0]  msk_q,
    input logic              irq_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (sts_q == '0 && msk_q == '0 && !irq_o));

    // R2
    rx_done_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_done_i |=> sts_q[POS_RX_DONE]);

    // R4
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_i && bus_addr_i == 2'd1 && bus_wdata_i[POS_BUS_FAULT] && !bus_fault_i)
        |=> !sts_q[POS_BUS_FAULT]);

    // R5
    set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_done_i && bus_wr_i && bus_addr_i == 2'd1) |=> sts_q[POS_RX_DONE]);

    // R6
    soft_raise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_i && bus_addr_i == 2'd2 && bus_wdata_i[0]) |=> sts_q[POS_SOFT]);

    // R8
    mask_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (msk_q == '0) |-> !irq_o);

    // R9
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones((sts_q | msk_q) & ~IMPL_BITS) == 0);
endmodule

bind irq_unit irq_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .rx_done_i   (rx_done_i),
    .bus_fault_i (bus_fault_i),
    .sts_q       (sts_q),
    .msk_q       (msk_q),
    .irq_o       (irq_o)
);

// File: tb/irq_unit_tb.sv
module irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [9:0]  ev;
    logic        irq;

    always #4 clk = ~clk;

    irq_unit u_dut (
        .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .rx_done_i(ev[0]), .rx_fault_i(ev[1]), .tx_done_i(ev[2]), .tx_fault_i(ev[3]),
        .rx_ring_empty_i(ev[4]), .link_event_i(ev[5]), .rx_fifo_full_i(ev[6]),
        .tx_ring_empty_i(ev[7]), .timer_i(ev[8]), .bus_fault_i(ev[9]), .irq_o(irq)
    );

    // positions from R2, in event-vector order
    int pos [10] = '{0, 1, 2, 3, 4, 5, 6, 7, 14, 15};
    localparam logic [15:0] LIVE = 16'hC1FF;

    typedef struct { string tag; logic [15:0] exp; logic exp_irq; } item_t;
    item_t q[$];

    int runs = 0, fails = 0;
    bit finished = 0;
    logic [15:0] m_sts, m_en;

    function automatic logic [15:0] ev_bits(input logic [9:0] e);
        logic [15:0] v = '0;
        for (int i = 0; i < 10; i++) if (e[i]) v[pos[i]] = 1'b1;
        return v;
    endfunction

    // one bus cycle with optional events; model updated per requirements
    task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d,
                        input logic [9:0] e);
        logic [15:0] set, clr;
        @(negedge clk);
        wr = w; addr = a; wdata = d; ev = e;
        @(posedge clk);
        set = ev_bits(e);
        clr = '0;
        if (w && a == 2'd2 && d[0]) set[8] = 1'b1;
        if (w && a == 2'd1) clr = d;
        if (w && a == 2'd0) m_en = d & LIVE;
        m_sts = ((m_sts & ~clr) | set) & LIVE;
        @(negedge clk);
        wr = 0; ev = '0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input string tag);
        item_t it;
        @(negedge clk);
        wr = 0; ev = '0; addr = a;
        it.tag = tag;
        it.exp = (a == 2'd0) ? m_en : (a == 2'd1) ? m_sts : 16'h0000;
        it.exp_irq = |(m_sts & m_en);
        q.push_back(it);
        @(posedge clk);
        #3;
    endtask

    // monitor: compares outputs away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                runs++;
                if (rdata !== it.exp || irq !== it.exp_irq) begin
                    fails++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, rdata, irq, it.exp, it.exp_irq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            runs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; wr = 0; addr = 0; wdata = 0; ev = '0;
        m_sts = 0; m_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        expect_rd(2'd1, "R1 status after reset");
        expect_rd(2'd0, "R1 enable after reset");

        // R2 and R3: each source latches at its position with mask zero
        for (int i = 0; i < 10; i++) begin
            step(0, 2'd0, 0, 10'(1) << i);
            expect_rd(2'd1, $sformatf("R2 R3 source %0d", i));
            step(1, 2'd1, 16'hFFFF, '0);
        end
        expect_rd(2'd1, "R4 all cleared by 0xFFFF");

        // R3 masked event visible; R8 no request
        step(0, 2'd0, 0, 10'b0000001000);
        expect_rd(2'd1, "R3 R8 masked tx_fault visible, irq low");

        // R7 R9: enable load and readback with reserved bits dropped
        step(1, 2'd0, 16'hFFFF, '0);
        expect_rd(2'd0, "R7 R9 enable readback");
        expect_rd(2'd1, "R8 irq rises once enabled");

        // R4: zeros do nothing, a one clears that bit only
        step(0, 2'd0, 0, 10'b1000000001);
        step(1, 2'd1, 16'h0000, '0);
        expect_rd(2'd1, "R4 write zero no change");
        step(1, 2'd1, 16'h0008, '0);
        expect_rd(2'd1, "R4 single bit clear");

        // R9: reserved status bits ignore writes
        step(1, 2'd1, 16'h3E00, '0);
        expect_rd(2'd1, "R9 reserved write no effect");

        // R6: command offset
        step(1, 2'd1, 16'hFFFF, '0);
        step(1, 2'd2, 16'hFFFE, '0);
        expect_rd(2'd1, "R6 command without bit0");
        step(1, 2'd2, 16'h0001, '0);
        expect_rd(2'd1, "R6 soft event raised");

        // R5: event in the same cycle as its clear
        step(1, 2'd1, 16'hFFFF, 10'b0000000001);
        expect_rd(2'd1, "R5 event survives clear");
        step(1, 2'd1, 16'hFFFF, 10'b1000000000);
        expect_rd(2'd1, "R5 bus_fault survives clear");

        // R10: other offsets read zero
        expect_rd(2'd2, "R10 command offset reads zero");
        expect_rd(2'd3, "R10 unused offset reads zero");

        // R8: only enabled bits raise the request
        step(1, 2'd1, 16'hFFFF, '0);
        step(1, 2'd0, 16'h8000, '0);
        step(0, 2'd0, 0, 10'b0000000001);
        expect_rd(2'd1, "R8 disabled bit no irq");
        step(0, 2'd0, 0, 10'b1000000000);
        expect_rd(2'd1, "R8 enabled bit raises irq");
        step(1, 2'd0, 16'h0000, '0);
        expect_rd(2'd0, "R8 zero enable suppresses irq");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule